// File: doc/BRIEF.md
# Dual-role serial peripheral interface port

This block is a four-wire synchronous serial port that software drives through two 8-bit registers on a simple register bus. A control/status register chooses the role, bit rate, bit order and chip-select use, and it reports completion and write collisions. A data register holds the bytes. A write to the data register loads a transmit holding buffer. A read returns the shift register, which holds the last received byte.

In master role the port makes its own serial clock from the system clock. A two-level divider sets the rate, and each data write starts one 8-bit exchange. In slave role an external master supplies the clock. That clock, the data input and the select input pass through two synchronizer flops, and their edges are found in the system clock domain. Every pad has an output enable, so the port releases its lines when it is disabled.

Top module: `spi_port`

## Requirements
- R1: The control register sits at address 0 and the data register at address 1. Control bits from 7 down to 0 are: base clock select, mode[1:0], enable, msb_first, cs_use, collision flag, done flag. Reset sets the control register to 0x60.
- R2: After reset, sck_oe, sdo_oe and scs_oe are 0 and sck_o is 0.
- R3: In master role each SCK half-period lasts P system cycles. P is B×D, where B is 1 when the base clock select is 1 and 4 when it is 0. D is 1 for mode 00, 4 for mode 01 and 16 for mode 10.
- R4: In master role (mode 00, 01 or 10), an enabled data write starts an 8-bit exchange. The done flag (bit 0) then rises, and a read of address 1 returns the byte received on sdi_i.
- R5: When msb_first is 1, bit 7 goes out and comes in first. When it is 0, bit 0 goes first. The same order applies to sdo_o and sdi_i.
- R6: sdo_o changes on the rising (leading) SCK edge and sdi_i is sampled on the falling edge. While the master is idle, sck_o is 0.
- R7: A data write loads only the transmit buffer. Until the first clock edge of the next byte, reads of address 1 still return the previously received byte.
- R8: A data write during a transfer sets the collision flag (bit 1) and leaves the buffer unchanged, so the byte in flight is still the one first written.
- R9: Writing 1 to a flag bit leaves that flag as it is. Writing 0 clears it.
- R10: In slave role (mode 11), external SCK rising edges put the next buffer bit on sdo_o and falling edges shift in sdi_i. The done flag rises after the eighth bit.
- R11: When cs_use is 1, a slave ignores SCK and releases sdo_o while scs_i is 0. A master drives scs_o=1 with scs_oe=1 during a transfer.
- R12: When enable is 0, sck_oe, sdo_oe and scs_oe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master role |
| sck_oe | output | 1 | Output enable for sck_o |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo_o |
| scs_i | input | 1 | Chip select in, active high, slave role |
| scs_o | output | 1 | Chip select out, master role |
| scs_oe | output | 1 | Output enable for scs_o |

## Verification
The hardest condition to reach from the ports is a data write that arrives while a byte is in flight. The bench sets up the slowest master rate so a transfer lasts more than a thousand cycles. It issues a second write a few cycles after the first, then checks that the peer captured the first byte and that the collision flag is up. The buffer-versus-shift-register split is also hard to observe. To reach it, the bench writes a new buffer value in slave role with no clock, reads back the old received byte, and then checks that the new value goes out once the selected external clock runs.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = $clog2(DATA_W);
    localparam int PRE_DIV    = 4;
    localparam int RATIO_MID  = 4;
    localparam int RATIO_SLOW = 16;
    localparam int DIV_W      = $clog2(PRE_DIV * RATIO_SLOW) + 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_QUART = 2'b01,
        MODE_SIXT  = 2'b10,
        MODE_SLAVE = 2'b11
    } mode_e;

    typedef struct packed {
        logic  fast_clk;
        mode_e mode;
        logic  enable;
        logic  msb_first;
        logic  cs_use;
        logic  wcol;
        logic  done;
    } ctrl_t;

    localparam logic [DATA_W-1:0] CTRL_RST = 8'h60;

    function automatic logic [DIV_W-1:0] rate_limit(input logic fast_clk, input mode_e m);
        int unsigned base;
        int unsigned mult;
        base = fast_clk ? 1 : PRE_DIV;
        case (m)
            MODE_FULL:  mult = 1;
            MODE_QUART: mult = RATIO_MID;
            default:    mult = RATIO_SLOW;
        endcase
        return DIV_W'(base * mult - 1);
    endfunction

    function automatic logic first_bit(input logic [DATA_W-1:0] v, input logic msb);
        return msb ? v[DATA_W-1] : v[0];
    endfunction
endpackage

// File: rtl/spi_port_rate.sv
`timescale 1ns/1ps
module spi_port_rate
    import spi_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  fast_clk,
    input  mode_e mode,
    output logic  tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    assign limit = rate_limit(fast_clk, mode);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // R3: with a divide above one, two ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> (!tick || limit == '0));
endmodule

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_port_shift.sv
`timescale 1ns/1ps
module spi_port_shift
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              msb_first,
    input  logic              wr_stb,
    input  logic              hold,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lead_ev,
    input  logic              trail_ev,
    input  logic              sdi,
    output logic [DATA_W-1:0] shift_o,
    output logic              sdo,
    output logic              in_byte,
    output logic              done_pulse
);
    logic [DATA_W-1:0] txbuf_q;
    logic [DATA_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              in_byte_q;
    logic              sdo_q;
    logic              load_ok;
    logic              last_bit;

    assign load_ok    = wr_stb && !in_byte_q && !hold;
    assign last_bit   = trail_ev && in_byte_q && (cnt_q == CNT_W'(DATA_W - 1));
    assign done_pulse = last_bit && !clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            txbuf_q   <= '0;
            shift_q   <= '0;
            cnt_q     <= '0;
            in_byte_q <= 1'b0;
            sdo_q     <= 1'b0;
        end else begin
            if (load_ok) txbuf_q <= wr_data;
            if (clear) begin
                cnt_q     <= '0;
                in_byte_q <= 1'b0;
                sdo_q     <= 1'b0;
            end else if (lead_ev) begin
                if (!in_byte_q) begin
                    shift_q   <= txbuf_q;
                    in_byte_q <= 1'b1;
                    sdo_q     <= first_bit(txbuf_q, msb_first);
                end else begin
                    sdo_q <= first_bit(shift_q, msb_first);
                end
            end else if (trail_ev && in_byte_q) begin
                shift_q <= msb_first ? {shift_q[DATA_W-2:0], sdi}
                                     : {sdi, shift_q[DATA_W-1:1]};
                if (last_bit) begin
                    cnt_q     <= '0;
                    in_byte_q <= 1'b0;
                    sdo_q     <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign shift_o = shift_q;
    assign sdo     = sdo_q;
    assign in_byte = in_byte_q;

    // R8: a write landing mid-byte must not disturb the holding buffer
    a_r8_buffer_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && in_byte_q) |=> $stable(txbuf_q));
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        sck_i,
    output logic        sck_o,
    output logic        sck_oe,
    input  logic        sdi_i,
    output logic        sdo_o,
    output logic        sdo_oe,
    input  logic        scs_i,
    output logic        scs_o,
    output logic        scs_oe
);
    ctrl_t             ctrl_q;
    logic              wr_ctrl, wr_data, is_slave, en;
    logic [2:0]        sync_v;
    logic              sck_s, sdi_s, scs_s, sck_d_q, sel;
    logic              mst_busy_q, sck_q, tick;
    logic              lead_ev, trail_ev, busy, collide, start;
    logic              in_byte, done_pulse, sdo_w;
    logic [DATA_W-1:0] shift_w;

    assign wr_ctrl  = reg_wr && !reg_addr;
    assign wr_data  = reg_wr && reg_addr;
    assign is_slave = (ctrl_q.mode == MODE_SLAVE);
    assign en       = ctrl_q.enable;

    spi_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .async_i({sck_i, sdi_i, scs_i}), .sync_o(sync_v)
    );
    assign {sck_s, sdi_s, scs_s} = sync_v;
    assign sel = !ctrl_q.cs_use || scs_s;

    always_ff @(posedge clk) begin
        if (rst) sck_d_q <= 1'b0;
        else     sck_d_q <= sck_s;
    end

    spi_port_rate rate_i (
        .clk(clk), .rst(rst), .run(mst_busy_q && !is_slave),
        .fast_clk(ctrl_q.fast_clk), .mode(ctrl_q.mode), .tick(tick)
    );

    always_comb begin
        if (is_slave) begin
            lead_ev  = en && sel && sck_s && !sck_d_q;
            trail_ev = en && sel && !sck_s && sck_d_q;
        end else begin
            lead_ev  = en && tick && !sck_q;
            trail_ev = en && tick && sck_q;
        end
    end

    assign busy    = mst_busy_q || in_byte;
    assign collide = wr_data && en && busy;
    assign start   = wr_data && en && !is_slave && !busy;

    spi_port_shift shift_i (
        .clk(clk), .rst(rst), .clear(!en), .msb_first(ctrl_q.msb_first),
        .wr_stb(wr_data), .hold(mst_busy_q), .wr_data(reg_wdata),
        .lead_ev(lead_ev), .trail_ev(trail_ev),
        .sdi(is_slave ? sdi_s : sdi_i),
        .shift_o(shift_w), .sdo(sdo_w), .in_byte(in_byte), .done_pulse(done_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst || !en || is_slave) begin
            mst_busy_q <= 1'b0;
            sck_q      <= 1'b0;
        end else begin
            if (start)           mst_busy_q <= 1'b1;
            else if (done_pulse) mst_busy_q <= 1'b0;
            if (lead_ev)         sck_q <= 1'b1;
            else if (trail_ev)   sck_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RST);
        end else begin
            if (wr_ctrl) begin
                ctrl_q.fast_clk  <= reg_wdata[7];
                ctrl_q.mode      <= mode_e'(reg_wdata[6:5]);
                ctrl_q.enable    <= reg_wdata[4];
                ctrl_q.msb_first <= reg_wdata[3];
                ctrl_q.cs_use    <= reg_wdata[2];
                ctrl_q.wcol      <= ctrl_q.wcol & reg_wdata[1];
                ctrl_q.done      <= ctrl_q.done & reg_wdata[0];
            end
            if (collide)    ctrl_q.wcol <= 1'b1;
            if (done_pulse) ctrl_q.done <= 1'b1;
        end
    end

    assign reg_rdata = reg_addr ? shift_w : ctrl_q;

    assign sck_o  = !is_slave && sck_q;
    assign sck_oe = en && !is_slave;
    assign sdo_o  = sdo_w;
    assign sdo_oe = en && (!is_slave || sel);
    assign scs_o  = !is_slave && ctrl_q.cs_use && mst_busy_q;
    assign scs_oe = en && ctrl_q.cs_use && !is_slave;

    // R1: the control register holds its documented value after reset
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (ctrl_q == ctrl_t'(CTRL_RST)));
    // R8: a data write during a byte raises the collision flag
    a_r8_collision_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_data && en && (mst_busy_q || in_byte)) |=> ctrl_q.wcol);
    // R6: an idle enabled master keeps its clock low
    a_r6_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
        (en && !is_slave && !mst_busy_q) |-> !sck_o);
    // R12: a disabled port drives none of its pads
    a_r12_released: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(sck_oe || sdo_oe || scs_oe));
    // R4: a finished master byte ends the busy state
    a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && !is_slave && en) |=> !mst_busy_q);
endmodule

// File: tb/spi_port_tb_top.sv
`timescale 1ns/1ps
module spi_port_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sck_i = 1'b0, scs_i = 1'b0, tb_sdi = 1'b0, mst_test = 1'b0;
    logic       sdi_i, sck_o, sck_oe, sdo_o, sdo_oe, scs_o, scs_oe;

    logic [7:0] pk_tx = 8'h00, pk_cap = 8'h00, hi_cnt = 8'h00, last_hi = 8'h00;
    logic       pk_msb = 1'b0, pk_sdi = 1'b0, pk_prev = 1'b0;
    logic [2:0] pk_idx = 3'd0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign sdi_i = mst_test ? pk_sdi : tb_sdi;

    spi_port dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .scs_i(scs_i), .scs_o(scs_o), .scs_oe(scs_oe)
    );

    // peer device on the master's lines: sees sdo at rise, answers on sdi
    always @(negedge clk) begin
        if (sck_o && !pk_prev) begin
            pk_cap <= pk_msb ? {pk_cap[6:0], sdo_o} : {sdo_o, pk_cap[7:1]};
            pk_sdi <= pk_msb ? pk_tx[7 - pk_idx] : pk_tx[pk_idx];
            pk_idx <= pk_idx + 3'd1;
        end
        if (sck_o) hi_cnt <= hi_cnt + 8'd1;
        else if (pk_prev) begin
            last_hi <= hi_cnt;
            hi_cnt  <= 8'd0;
        end
        pk_prev <= sck_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [7:0] c;
        int n = 0;
        c = 8'h00;
        while (!c[0] && n < 5000) begin
            reg_read(1'b0, c);
            n++;
        end
        chk(req, {31'd0, c[0]}, 32'd1);
    endtask

    // one slave byte driven from the bench; returns what the port sent
    task automatic slave_byte(input logic msb, input logic [7:0] mo, output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tb_sdi = msb ? mo[7 - i] : mo[i];
            @(negedge clk); sck_i = 1'b1;
            repeat (8) @(negedge clk);
            if (msb) got = {got[6:0], sdo_o};
            else     got = {sdo_o, got[7:1]};
            sck_i = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    // vector: {cks, mode[1:0], msb, csen, tx[7:0], peer[7:0], half-period[7:0]}
    localparam int NV = 6;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 2'b00, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'd1},
        {1'b1, 2'b01, 1'b0, 1'b0, 8'h8E, 8'h7E, 8'd4},
        {1'b1, 2'b10, 1'b1, 1'b0, 8'h0F, 8'hF0, 8'd16},
        {1'b0, 2'b00, 1'b0, 1'b1, 8'hC3, 8'h55, 8'd4},
        {1'b0, 2'b01, 1'b1, 1'b0, 8'h01, 8'h80, 8'd16},
        {1'b0, 2'b10, 1'b0, 1'b0, 8'hFF, 8'h00, 8'd64}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 R2: reset state
        reg_read(1'b0, rd);
        chk("R1 reset control value", rd, 8'h60);
        chk("R2 pads released after reset", {sck_oe, sdo_oe, scs_oe, sck_o}, 4'b0000);

        // R3 R4 R5 R6 R11: master vectors
        mst_test = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [7:0] cv;
            cv = {VEC[v][28], VEC[v][27:26], 1'b1, VEC[v][25], VEC[v][24], 2'b00};
            pk_tx  = VEC[v][15:8];
            pk_msb = VEC[v][25];
            reg_write(1'b0, cv);
            reg_write(1'b1, VEC[v][23:16]);
            @(negedge clk);
            chk("R11 master select out", {scs_o, scs_oe}, {2{VEC[v][24]}});
            wait_done("R4 master done flag");
            reg_read(1'b1, rd);
            chk("R4 R5 master received byte", rd, VEC[v][15:8]);
            chk("R5 R6 peer captured byte", pk_cap, VEC[v][23:16]);
            chk("R3 clock half-period", last_hi, VEC[v][7:0]);
            chk("R6 clock low when idle", sck_o, 1'b0);
            reg_write(1'b0, cv);
        end

        // R8: collision in flight, slowest rate
        pk_tx = 8'h99; pk_msb = 1'b1;
        reg_write(1'b0, 8'h58);
        reg_write(1'b1, 8'h6E);
        repeat (5) @(negedge clk);
        reg_write(1'b1, 8'h11);
        reg_read(1'b0, rd);
        chk("R8 collision flag set", rd[1], 1'b1);
        wait_done("R8 transfer still completes");
        chk("R8 buffer unchanged by late write", pk_cap, 8'h6E);
        reg_read(1'b1, rd);
        chk("R8 received byte", rd, 8'h99);

        // R9: flag write semantics
        reg_write(1'b0, 8'h5B);
        reg_read(1'b0, rd);
        chk("R9 writing ones keeps flags", rd[1:0], 2'b11);
        reg_write(1'b0, 8'h58);
        reg_read(1'b0, rd);
        chk("R9 writing zeros clears flags", rd, 8'h58);
        mst_test = 1'b0;

        // R10 R5: slave bytes
        reg_write(1'b0, 8'h78);
        reg_write(1'b1, 8'h5A);
        slave_byte(1'b1, 8'hC6, got);
        chk("R10 slave sent byte msb first", got, 8'h5A);
        wait_done("R10 slave done flag");
        reg_read(1'b1, rd);
        chk("R10 slave received byte", rd, 8'hC6);
        reg_write(1'b0, 8'h70);
        reg_write(1'b1, 8'h3B);
        slave_byte(1'b0, 8'h91, got);
        chk("R10 R5 slave sent byte lsb first", got, 8'h3B);
        reg_read(1'b1, rd);
        chk("R10 slave received lsb first", rd, 8'h91);

        // R7: write only loads the buffer
        reg_write(1'b1, 8'h44);
        reg_read(1'b1, rd);
        chk("R7 read returns shift register", rd, 8'h91);

        // R11: select gating in slave role
        reg_write(1'b0, 8'h74);
        scs_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 slave output released when unselected", sdo_oe, 1'b0);
        slave_byte(1'b0, 8'hE7, got);
        reg_read(1'b0, rd);
        chk("R11 unselected clocks ignored", rd[0], 1'b0);
        reg_read(1'b1, rd);
        chk("R11 shift register untouched", rd, 8'h91);
        scs_i = 1'b1;
        repeat (4) @(negedge clk);
        slave_byte(1'b0, 8'h2D, got);
        chk("R11 R7 selected slave sends buffered byte", got, 8'h44);
        reg_read(1'b1, rd);
        chk("R11 selected slave receives", rd, 8'h2D);

        // R12: disable
        reg_write(1'b0, 8'h48);
        reg_read(1'b0, rd);
        chk("R12 control after disable", rd, 8'h48);
        chk("R12 pads released when disabled", {sck_oe, sdo_oe, scs_oe}, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule